// File: doc/BRIEF.md
# AC'97 Controller Global Status Word

This block holds the global status word of an AC'97 digital controller. It gathers, in one word that software can read, events and levels from several places. These are resume events on the two serial data inputs (primary codec on input 0, secondary codec on input 1), the codec-ready indications from those inputs, and per-channel DMA interrupt flags grouped into five summaries. It also latches the "GPIO input changed" indication that the link decoder extracts from input slot 12. The latched GPIO-change bit drives a power-management status output.

Software reads the word through `rd_data`, which is always valid. It clears the event bits by writing ones through a single-cycle `wr_en` strobe. The block has no streaming data path, so every pin is a plain control or status level. There is no valid/ready handshake and no back-pressure. Frame decoding, the DMA engines and the link-clock health detector sit outside the block. They appear here only as input pulses or levels.

Top module: `ac_glob_status`

## Requirements
- R1: A pulse on `resume_evt[0]` sets bit 8 and a pulse on `resume_evt[1]` sets bit 9 of `rd_data` on the next clock edge. Each bit stays set until it is cleared.
- R2: A write with `wr_data[8]` = 1 clears bit 8 and a write with `wr_data[9]` = 1 clears bit 9 on that clock edge. Writing 0 to either position leaves the bit as it is.
- R3: Bit 6 mirrors `codec_rdy[0]` and bit 7 mirrors `codec_rdy[1]` with no clock delay. The codec-ready bits are informational only and gate nothing inside the block.
- R4: Bits 6 and 7 read 0 while `shutoff` is 1 or while `clk_bad` is 1.
- R5: Bits 1 to 5 are summaries: bit 1 is modem-in, bit 2 is modem-out, bit 3 is PCM-in, bit 4 is PCM-out and bit 5 is mic-in. Each bit is 1 exactly while any flag of its group is 1, and it drops with no clock delay once all flags of that group are 0.
- R6: A pulse on `gpi_evt` (slot 12 bit 0 received as 1) sets bit 0 on the next edge. A write with `wr_data[0]` = 1 clears it.
- R7: `pm_status` equals bit 0 at all times.
- R8: If a set event and a write-one clear hit the same sticky bit (0, 8 or 9) in the same cycle, the bit ends up 1.
- R9: Writes to bits 1 to 7 and to bits 10 to 15 have no effect. Bits 10 to 15 always read 0.
- R10: Synchronous reset (`rst` = 1 at a clock edge) clears bits 0, 8 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 16 | Write data, ones clear sticky bits |
| rd_data | output | 16 | Status word |
| resume_evt | input | 2 | Resume event pulses, index = serial input |
| codec_rdy | input | 2 | Codec-ready levels, index = serial input |
| shutoff | input | 1 | Controller shutoff control |
| clk_bad | input | 1 | Link bit clock detected inadequate |
| irq_modem_in | input | NCH | Modem-in channel interrupt flags |
| irq_modem_out | input | NCH | Modem-out channel interrupt flags |
| irq_pcm_in | input | NCH | PCM-in channel interrupt flags |
| irq_pcm_out | input | NCH | PCM-out channel interrupt flags |
| irq_mic | input | NCH | Mic-in channel interrupt flags |
| gpi_evt | input | 1 | Slot 12 bit 0 received as 1 |
| pm_status | output | 1 | Power-management AC'97 status |

## Verification
The bench targets these corner cases:

- **Same-cycle set and clear.** It drives a set and a write-one clear into the same sticky bit in one cycle. A design where the clear wins would silently lose a resume or GPIO event.
- **Every set/clear combination.** It sweeps all combinations of prior state, event and write bit for each sticky bit. A wrong bit mapping or a write-zero that clears shows up as a flipped bit, or as a disturbed neighbouring bit.
- **Codec-ready forcing.** It tries every combination of codec-ready inputs, `shutoff` and `clk_bad`. A design that forgot either forcing condition would report a codec as ready while the link is down.
- **Summaries.** It sweeps every pattern of the ten interrupt flags. A summary bit that was latched, or mapped to the wrong group, would fail to drop or would light the wrong bit.

// File: rtl/ac_gs_pkg.sv
package ac_gs_pkg;
  localparam int REG_W   = 16;
  localparam int N_CODEC = 2;
  localparam int N_GRP   = 5;
  // bit positions of the status word
  localparam int B_GPI  = 0;
  localparam int B_MI   = 1;
  localparam int B_MO   = 2;
  localparam int B_PI   = 3;
  localparam int B_PO   = 4;
  localparam int B_MIC  = 5;
  localparam int B_RDY0 = 6;
  localparam int B_RDY1 = 7;
  localparam int B_RES0 = 8;
  localparam int B_RES1 = 9;
  localparam int B_TOP  = B_RES1;
  localparam int N_STICKY = 3;
endpackage

// File: rtl/acgs_sticky.sv
module acgs_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_r;

  // set has priority over clear so an event is never lost
  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= (q_r & ~clr_i) | set_i;
  end

  assign q_o = q_r;
endmodule

// File: rtl/acgs_summary.sv
module acgs_summary #(
  parameter int NGRP = 5,
  parameter int NCH  = 2
) (
  input  logic [NGRP*NCH-1:0] flags_i,
  output logic [NGRP-1:0]     any_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign any_o[g] = |flags_i[g*NCH +: NCH];
  end
endmodule

// File: rtl/acgs_ready.sv
module acgs_ready #(
  parameter int N = 2
) (
  input  logic [N-1:0] rdy_i,
  input  logic         shutoff_i,
  input  logic         clk_bad_i,
  output logic [N-1:0] rdy_o
);
  logic force_low;
  assign force_low = shutoff_i | clk_bad_i;

  for (genvar c = 0; c < N; c++) begin : g_codec
    assign rdy_o[c] = rdy_i[c] & ~force_low;
  end
endmodule

// File: rtl/ac_glob_status.sv
module ac_glob_status
  import ac_gs_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic [N_CODEC-1:0] resume_evt,
  input  logic [N_CODEC-1:0] codec_rdy,
  input  logic               shutoff,
  input  logic               clk_bad,
  input  logic [NCH-1:0]     irq_modem_in,
  input  logic [NCH-1:0]     irq_modem_out,
  input  logic [NCH-1:0]     irq_pcm_in,
  input  logic [NCH-1:0]     irq_pcm_out,
  input  logic [NCH-1:0]     irq_mic,
  input  logic               gpi_evt,
  output logic               pm_status
);
  localparam int FLAG_W = N_GRP * NCH;

  // sticky slot order: 0 = GPIO change, 1 = resume primary, 2 = resume secondary
  logic [N_STICKY-1:0] st_set, st_clr, st_q;
  logic [FLAG_W-1:0]   flags;
  logic [N_GRP-1:0]    summ;
  logic [N_CODEC-1:0]  rdy_m;
  logic                unused_wr;

  assign st_set = {resume_evt[1], resume_evt[0], gpi_evt};
  assign st_clr = wr_en ? {wr_data[B_RES1], wr_data[B_RES0], wr_data[B_GPI]}
                        : '0;
  assign unused_wr = ^{wr_data[REG_W-1:B_TOP+1], wr_data[B_RDY1:B_MI]};

  acgs_sticky #(.N(N_STICKY)) u_sticky (
    .clk   (clk),
    .rst   (rst),
    .set_i (st_set),
    .clr_i (st_clr),
    .q_o   (st_q)
  );

  // group order matches status bits B_MI..B_MIC
  assign flags = {irq_mic, irq_pcm_out, irq_pcm_in, irq_modem_out, irq_modem_in};

  acgs_summary #(.NGRP(N_GRP), .NCH(NCH)) u_summary (
    .flags_i (flags),
    .any_o   (summ)
  );

  acgs_ready #(.N(N_CODEC)) u_ready (
    .rdy_i     (codec_rdy),
    .shutoff_i (shutoff),
    .clk_bad_i (clk_bad),
    .rdy_o     (rdy_m)
  );

  always_comb begin
    rd_data                 = '0;
    rd_data[B_GPI]          = st_q[0];
    rd_data[B_MIC:B_MI]     = summ;
    rd_data[B_RDY1:B_RDY0]  = rdy_m;
    rd_data[B_RES0]         = st_q[1];
    rd_data[B_RES1]         = st_q[2];
  end

  assign pm_status = st_q[0];
endmodule

// File: rtl/acgs_checker.sv
module acgs_checker
  import ac_gs_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic [REG_W-1:0]   rd_data,
  input logic [N_CODEC-1:0] resume_evt,
  input logic               shutoff,
  input logic               clk_bad,
  input logic [NCH-1:0]     irq_mic,
  input logic [NCH-1:0]     irq_modem_in,
  input logic               gpi_evt,
  input logic               pm_status
);
  logic unused_chk;
  assign unused_chk = ^{wr_data[REG_W-1:B_TOP+1], wr_data[B_RDY1:B_MI]};

  assert_res0_set_R1: assert property (@(posedge clk) disable iff (rst)
    resume_evt[0] |=> rd_data[B_RES0]);
  assert_res1_set_R1: assert property (@(posedge clk) disable iff (rst)
    resume_evt[1] |=> rd_data[B_RES1]);
  assert_res_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[B_RES0] && !resume_evt[0]) |=> !rd_data[B_RES0]);
  assert_res_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wr_data[B_RES1]) && !resume_evt[1]) |=> $stable(rd_data[B_RES1]));
  assert_rdy_forced_R4: assert property (@(posedge clk) disable iff (rst)
    (shutoff || clk_bad) |-> (rd_data[B_RDY1:B_RDY0] == 2'b00));
  assert_sum_mic_R5: assert property (@(posedge clk) disable iff (rst)
    rd_data[B_MIC] == (|irq_mic));
  assert_sum_mi_R5: assert property (@(posedge clk) disable iff (rst)
    rd_data[B_MI] == (|irq_modem_in));
  assert_gpi_set_R6: assert property (@(posedge clk) disable iff (rst)
    gpi_evt |=> rd_data[B_GPI]);
  assert_pm_follow_R7: assert property (@(posedge clk) disable iff (rst)
    pm_status == rd_data[B_GPI]);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[B_GPI] && gpi_evt) |=> rd_data[B_GPI]);
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    rd_data[REG_W-1:B_TOP+1] == '0);
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (rd_data[B_GPI] == 1'b0 && rd_data[B_RES1:B_RES0] == 2'b00));
endmodule

bind ac_glob_status acgs_checker #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .resume_evt   (resume_evt),
  .shutoff      (shutoff),
  .clk_bad      (clk_bad),
  .irq_mic      (irq_mic),
  .irq_modem_in (irq_modem_in),
  .gpi_evt      (gpi_evt),
  .pm_status    (pm_status)
);

// File: tb/ac_glob_status_tb.sv
module ac_glob_status_tb_top;
  localparam int NCH = 2;
  localparam int W   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [1:0] resume_evt = '0;
  logic [1:0] codec_rdy = '0;
  logic shutoff = 1'b0;
  logic clk_bad = 1'b0;
  logic [NCH-1:0] irq_mi = '0, irq_mo = '0, irq_pi = '0, irq_po = '0, irq_mic = '0;
  logic gpi_evt = 1'b0;
  logic pm_status;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ac_glob_status #(.NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .resume_evt(resume_evt), .codec_rdy(codec_rdy), .shutoff(shutoff),
    .clk_bad(clk_bad), .irq_modem_in(irq_mi), .irq_modem_out(irq_mo),
    .irq_pcm_in(irq_pi), .irq_pcm_out(irq_po), .irq_mic(irq_mic),
    .gpi_evt(gpi_evt), .pm_status(pm_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // sticky position for index k: 0 -> bit 0, 1 -> bit 8, 2 -> bit 9
  function automatic int spos(input int k);
    return (k == 0) ? 0 : (k == 1) ? 8 : 9;
  endfunction

  task automatic drive_evt(input int k, input logic v);
    if (k == 0) gpi_evt = v;
    else resume_evt[k-1] = v;
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_data = 16'h0301;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #40000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    tick(); tick();
    rst = 1'b0;
    chk("R10 reset state", rd_data, 32'h0);
    chk("R7 reset pm", pm_status, 0);

    // R1 R2 R6 R8: every combination of prior state, event, write-one
    for (int k = 0; k < 3; k++) begin
      for (int init = 0; init < 2; init++) begin
        for (int ev = 0; ev < 2; ev++) begin
          for (int cl = 0; cl < 2; cl++) begin
            logic [W-1:0] exp;
            clear_all();
            if (init == 1) begin
              drive_evt(k, 1'b1); tick(); drive_evt(k, 1'b0);
            end
            drive_evt(k, ev[0]);
            wr_en = 1'b1;
            wr_data = cl[0] ? (16'h1 << spos(k)) : 16'h0;
            tick();
            drive_evt(k, 1'b0); wr_en = 1'b0; wr_data = '0;
            exp = '0;
            exp[spos(k)] = ev[0] | (init[0] & ~cl[0]);
            if (ev == 1 && cl == 1)
              chk("R8 set wins over clear", rd_data, exp);
            else if (k == 0)
              chk("R6 gpi change bit", rd_data, exp);
            else if (cl == 1 || init == 0)
              chk("R2 resume clear/write0", rd_data, exp);
            else
              chk("R1 resume sticky", rd_data, exp);
            chk("R7 pm follows gpi", pm_status, exp[0]);
          end
        end
      end
    end

    // R3 R4: all ready/shutoff/clk_bad combinations
    clear_all();
    for (int p = 0; p < 16; p++) begin
      codec_rdy = p[1:0]; shutoff = p[2]; clk_bad = p[3];
      #1;
      chk((p[3:2] == 0) ? "R3 ready mirror" : "R4 ready forced low",
          rd_data, {24'h0, ((p[3:2] == 0) ? p[1:0] : 2'b00), 6'h0});
    end
    codec_rdy = '0; shutoff = 1'b0; clk_bad = 1'b0;

    // R5: every pattern of the ten interrupt flags
    for (int p = 0; p < 1024; p++) begin
      logic [4:0] es;
      {irq_mic, irq_po, irq_pi, irq_mo, irq_mi} = p[9:0];
      #1;
      for (int g = 0; g < 5; g++) es[g] = (p[2*g] | p[2*g+1]);
      chk("R5 summary bits", rd_data, {26'h0, es, 1'b0});
    end
    {irq_mic, irq_po, irq_pi, irq_mo, irq_mi} = '0;
    #1;
    chk("R5 summaries drop", rd_data, 32'h0);

    // R9: writes to read-only and reserved bits
    gpi_evt = 1'b1; resume_evt = 2'b11;
    tick();
    gpi_evt = 1'b0; resume_evt = 2'b00;
    wr_en = 1'b1; wr_data = 16'hFCFE;
    tick();
    wr_en = 1'b0; wr_data = '0;
    chk("R9 ro/reserved writes ignored", rd_data, 32'h0301);

    // R10: reset clears set sticky bits
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R10 reset clears sticky", rd_data, 32'h0);
    chk("R10 reset clears pm", pm_status, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule